// File: doc/BRIEF.md
# ADC autoscan sequence controller

This block is the digital sequencer that drives a multi-channel analog-to-digital converter. Software programs one 8-bit control register. The register holds a first channel, enables for two hardware trigger sources, a power-up bit, a continuous-mode bit and a run bit. Once running, the block walks from the programmed first channel up to channel 7. For each channel it gives the converter a one-cycle start strobe and then waits for the converter's done strobe.

A sequence can be started in three ways: by writing the run bit, by a falling edge on the active-low external trigger pin, or by a one-cycle strobe from an on-chip timer. Each trigger only counts when its enable bit is set. A trigger only sets the run bit. In single mode the hardware clears the run bit when the sequence ends. In continuous mode sequences repeat back to back until software clears the bit. Any register write aborts the conversion in flight and restarts the scan from the newly written settings. The analog converter itself, result storage and interrupt handling are outside this block.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset the control register reads 00h, `conv_start_o` is low and `eos_o` is low.
- R2: The register reads back what was last written. Its fields are: bits 7:5 first channel, bit 4 external trigger enable, bit 3 internal trigger enable, bit 2 power-up, bit 1 continuous mode, bit 0 run.
- R3: A sequence issues one-cycle `conv_start_o` strobes for channels first, first+1, ... up to 7, in that order. Each next strobe follows the `conv_done_i` of the previous conversion, and `conv_ch_o` holds the channel during its strobe.
- R4: With first channel 7, a sequence converts only channel 7.
- R5: In single mode (bit 1 = 0), completing channel 7 produces exactly one one-cycle `eos_o` pulse and clears the run bit. No further conversions follow.
- R6: In continuous mode (bit 1 = 1), a new sequence restarts at the first channel right after channel 7 completes. `eos_o` pulses at each sequence end, until a write clears the run bit; after that no conversion is issued.
- R7: With bit 4 set, a low-going edge on `ext_trig_ni` sets the run bit and starts a sequence. With bit 4 clear, the edge has no effect.
- R8: With bit 3 set, a one-cycle high strobe on `int_evt_i` sets the run bit and starts a sequence. With bit 3 clear, the strobe has no effect.
- R9: While bit 2 is 0, no `conv_start_o` is issued even if the run bit is 1, and triggers do not set the run bit.
- R10: A register write aborts the sequence in progress. No strobe is issued in the cycle after the write, and the scan restarts from the newly written first channel when run and power-up are set.
- R11: A trigger that arrives while a sequence is running does not start an extra sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register contents |
| ext_trig_ni | input | 1 | Asynchronous external trigger, active low |
| int_evt_i | input | 1 | On-chip timer event strobe |
| conv_start_o | output | 1 | One-cycle start to converter |
| conv_done_i | input | 1 | One-cycle conversion done from converter |
| conv_ch_o | output | 3 | Channel being converted |
| eos_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench goes after the sequence end. A design that stops at the wrong channel, or that wraps a first channel of 7 into channel 0, logs the wrong channel list. It also aims a write at a scan in mid-flight. A design that resumes the old counter instead of restarting shows stale channels after the write. Triggers are sent while a sequence is running, while disabled and while powered down, so a design that queues them or ignores their gating runs a second sequence. In continuous mode the bench checks that a clear of the run bit really halts the scan, so a design that keeps it latched keeps issuing strobes.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned NUM_CH = 8;
  localparam int unsigned CH_W   = $clog2(NUM_CH);

  typedef struct packed {
    logic [CH_W-1:0] first_ch;
    logic            ext_en;
    logic            int_en;
    logic            pwr_up;
    logic            cont;
    logic            run;
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } scan_st_e;
endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_ni};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
  import adc_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       trig_set_i,
  input  logic       hw_clr_i,
  output ctrl_t      ctrl_o
);
  ctrl_t ctrl_q;

  // write wins over trigger and hardware clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_en_i) begin
      ctrl_q <= ctrl_t'(wr_data_i);
    end else if (hw_clr_i) begin
      ctrl_q.run <= 1'b0;
    end else if (trig_set_i) begin
      ctrl_q.run <= 1'b1;
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_seq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            abort_i,
  input  logic [CH_W-1:0] first_ch_i,
  input  logic            run_i,
  input  logic            pwr_i,
  input  logic            cont_i,
  input  logic            done_i,
  output logic            start_o,
  output logic [CH_W-1:0] ch_o,
  output logic            eos_o,
  output logic            hw_clr_o
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  scan_st_e        st_q;
  logic [CH_W-1:0] ch_q;
  logic            eos_q;
  logic            last_done;

  assign last_done = (st_q == ST_WAIT) && done_i && (ch_q == LAST_CH) && !abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ch_q  <= '0;
      eos_q <= 1'b0;
    end else begin
      eos_q <= last_done;
      if (abort_i) begin
        st_q <= ST_IDLE;
        ch_q <= '0;
      end else begin
        unique case (st_q)
          ST_IDLE: if (run_i && pwr_i) begin
            ch_q <= first_ch_i;
            st_q <= ST_ISSUE;
          end
          ST_ISSUE: st_q <= ST_WAIT;
          ST_WAIT: if (done_i) begin
            if (ch_q == LAST_CH) begin
              if (cont_i) begin
                ch_q <= first_ch_i;
                st_q <= ST_ISSUE;
              end else begin
                st_q <= ST_IDLE;
              end
            end else begin
              ch_q <= ch_q + 1'b1;
              st_q <= ST_ISSUE;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign start_o  = (st_q == ST_ISSUE);
  assign ch_o     = ch_q;
  assign eos_o    = eos_q;
  assign hw_clr_o = last_done && !cont_i;
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [7:0]      wr_data_i,
  output logic [7:0]      rd_data_o,
  input  logic            ext_trig_ni,
  input  logic            int_evt_i,
  output logic            conv_start_o,
  input  logic            conv_done_i,
  output logic [CH_W-1:0] conv_ch_o,
  output logic            eos_o
);
  ctrl_t ctrl;
  logic  ext_fall, trig_set, hw_clr;

  adc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_ni(ext_trig_ni),
    .fall_o(ext_fall)
  );

  // qualified sources are ORed; no trigger while powered down
  assign trig_set = ctrl.pwr_up &
                    ((ctrl.ext_en & ext_fall) | (ctrl.int_en & int_evt_i));

  adc_ctrl_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .trig_set_i(trig_set),
    .hw_clr_i  (hw_clr),
    .ctrl_o    (ctrl)
  );

  adc_scan_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .abort_i   (wr_en_i),
    .first_ch_i(ctrl.first_ch),
    .run_i     (ctrl.run),
    .pwr_i     (ctrl.pwr_up),
    .cont_i    (ctrl.cont),
    .done_i    (conv_done_i),
    .start_o   (conv_start_o),
    .ch_o      (conv_ch_o),
    .eos_o     (eos_o),
    .hw_clr_o  (hw_clr)
  );

  assign rd_data_o = ctrl;
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] rd_data_o,
  input logic       conv_start_o,
  input logic       conv_done_i,
  input logic [2:0] conv_ch_o,
  input logic       eos_o
);
  assert_start_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  assert_eos_after_last_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_o |-> ($past(conv_ch_o) == 3'd7 && $past(conv_done_i)));

  assert_eos_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_o |=> !eos_o);

  assert_single_clears_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eos_o && !rd_data_o[1]) |-> !rd_data_o[0]);

  assert_no_start_powered_down_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> (rd_data_o[2] && rd_data_o[0]));

  assert_write_aborts_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !conv_start_o);
endmodule

bind adc_scan_ctrl adc_scan_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .rd_data_o   (rd_data_o),
  .conv_start_o(conv_start_o),
  .conv_done_i (conv_done_i),
  .conv_ch_o   (conv_ch_o),
  .eos_o       (eos_o)
);

// File: tb/sim_adc_scan_ctrl.sv
`timescale 1ns/1ps
module sim_adc_scan_ctrl;
  localparam int LAT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       ext_n = 1'b1;
  logic       int_evt = 1'b0;
  logic       cstart;
  logic       cdone = 1'b0;
  logic [2:0] cch;
  logic       eos;

  int n_chk = 0;
  int n_bad = 0;
  int log_ch [64];
  int log_n = 0;
  int eos_n = 0;
  int lat_cnt = 0;

  always #4 clk = ~clk;

  adc_scan_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .ext_trig_ni(ext_n), .int_evt_i(int_evt),
    .conv_start_o(cstart), .conv_done_i(cdone), .conv_ch_o(cch), .eos_o(eos)
  );

  // converter model and monitor, both away from the active edge
  always @(negedge clk) begin
    cdone = 1'b0;
    if (lat_cnt != 0) begin
      lat_cnt = lat_cnt - 1;
      if (lat_cnt == 0) cdone = 1'b1;
    end
    if (cstart) begin
      lat_cnt = LAT;
      if (log_n < 64) log_ch[log_n] = int'(cch);
      log_n = log_n + 1;
    end
    if (eos) eos_n = eos_n + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clr_log();
    log_n = 0; eos_n = 0;
  endtask

  task automatic chk_seq(input string req, input int first);
    chk({req, " count"}, log_n, 8 - first);
    for (int i = 0; i < 8 - first && i < log_n; i++)
      chk({req, " channel"}, log_ch[i], first + i);
  endtask

  task automatic t_reset();
    chk("R1 reg", int'(rd_data), 0);
    chk("R1 start", int'(cstart), 0);
    chk("R1 eos", int'(eos), 0);
  endtask

  task automatic t_readback();
    wr(8'hF4);
    cyc(2);
    chk("R2 readback", int'(rd_data), 8'hF4);
    chk("R2 no start", log_n, 0);
    wr(8'h00);
  endtask

  task automatic t_single(input int first, input string req);
    clr_log();
    wr({first[2:0], 5'b00101});
    cyc(70);
    chk_seq(req, first);
    chk("R5 one eos", eos_n, 1);
    chk("R5 run cleared", int'(rd_data), int'({first[2:0], 5'b00100}));
  endtask

  task automatic t_cont();
    bit ok;
    clr_log();
    wr(8'b110_00111);
    cyc(50);
    wr(8'b110_00110);
    ok = (log_n >= 4);
    for (int i = 0; i < log_n && i < 64; i++)
      if (log_ch[i] != 6 + (i % 2)) ok = 0;
    chk("R6 alternating 6,7 repeats", int'(ok), 1);
    chk("R6 eos each sequence", int'(eos_n >= 2), 1);
    clr_log();
    cyc(40);
    chk("R6 stopped", log_n, 0);
    chk("R6 run reads 0", int'(rd_data[0]), 0);
  endtask

  task automatic t_ext();
    clr_log();
    wr(8'b100_10100);
    @(negedge clk) ext_n = 1'b0;
    cyc(2);
    ext_n = 1'b1;
    cyc(70);
    chk_seq("R7 ext", 4);
    chk("R7 run cleared", int'(rd_data[0]), 0);
    clr_log();
    wr(8'b100_00100);
    @(negedge clk) ext_n = 1'b0;
    cyc(2);
    ext_n = 1'b1;
    cyc(30);
    chk("R7 disabled no conv", log_n, 0);
    chk("R7 disabled run 0", int'(rd_data[0]), 0);
  endtask

  task automatic t_int();
    clr_log();
    wr(8'b101_01100);
    @(negedge clk) int_evt = 1'b1;
    @(negedge clk) int_evt = 1'b0;
    cyc(60);
    chk_seq("R8 int", 5);
    clr_log();
    wr(8'b101_00100);
    @(negedge clk) int_evt = 1'b1;
    @(negedge clk) int_evt = 1'b0;
    cyc(30);
    chk("R8 disabled no conv", log_n, 0);
    chk("R8 disabled run 0", int'(rd_data[0]), 0);
  endtask

  task automatic t_busy_trig();
    clr_log();
    wr(8'b010_01100);
    @(negedge clk) int_evt = 1'b1;
    @(negedge clk) int_evt = 1'b0;
    while (log_n < 2) @(negedge clk);
    int_evt = 1'b1;
    @(negedge clk) int_evt = 1'b0;
    cyc(80);
    chk_seq("R11 busy trigger", 2);
    chk("R11 one eos", eos_n, 1);
  endtask

  task automatic t_power();
    clr_log();
    wr(8'b000_01001);
    @(negedge clk) int_evt = 1'b1;
    @(negedge clk) int_evt = 1'b0;
    cyc(40);
    chk("R9 no conv powered down", log_n, 0);
    chk("R9 reg kept", int'(rd_data), 8'h09);
    wr(8'b110_00101);
    cyc(40);
    chk_seq("R9 after power up", 6);
  endtask

  task automatic t_abort();
    clr_log();
    wr(8'b000_00101);
    while (log_n < 2) @(negedge clk);
    wr(8'b011_00101);
    cyc(70);
    chk("R10 count", log_n, 7);
    chk("R10 ch0", log_ch[0], 0);
    chk("R10 ch1", log_ch[1], 1);
    for (int i = 2; i < 7 && i < log_n; i++)
      chk("R10 restart channel", log_ch[i], i + 1);
    chk("R10 one eos", eos_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_readback();
    t_single(5, "R3 from 5");
    t_single(0, "R3 from 0");
    t_single(7, "R4 only 7");
    t_cont();
    t_ext();
    t_int();
    t_busy_trig();
    t_power();
    t_abort();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule